// File: doc/BRIEF.md
# Pausible Local Clock Generator

This block produces a module clock from a fast reference clock by dividing it with a programmable half-period. Either of two handshake requests can interrupt the clock. The two request lines are merged into one internal request without first deciding which came first. A mutual-exclusion step then weighs that request against the clock's next rising edge. When the request wins, it receives a grant, and the low phase of the module clock is held for as long as that grant stays up.

The grant goes to exactly one requester. Input A has priority when both request lines are active. A requester is expected to drop its line as soon as it sees its grant, which releases the clock. A counter reports how many reference cycles the clock has spent held at its rising point. The model works cycle by cycle on the reference clock; every register updates on its rising edge.

Top module: `pausible_clkgen`

## Requirements
- R1: While reset is asserted, `mclk`, `gnt_a` and `gnt_b` are low and `pause_cnt` is zero. After reset, the first low phase begins.
- R2: With no requests, every high phase and every low phase of `mclk` lasts H reference cycles. `freq_sel` 0, 1, 2 and 3 select H = 4, 5, 6 and 8.
- R3: Suppose a request line is high at a reference edge while `mclk` is low and the low phase is not at its last cycle. The grant then rises at that edge, so it is visible one reference cycle after the request was applied.
- R4: A request applied while `mclk` is high gets no grant during the high phase. Its grant rises one reference cycle after `mclk` falls, which is H+1 cycles after the request if it was applied right after a rising edge.
- R5: A request that first appears at the edge where `mclk` is due to rise loses to the clock. `mclk` rises on time, and the grant follows one cycle after the next fall, which is H+2 cycles after the request.
- R6: `mclk` stays low while any grant is high. A grant that is released before the rising point leaves the low phase at H cycles. If a grant is held past the rising point, `mclk` rises two reference edges after the edge at which the requester dropped its line.
- R7: When both requests are present at the granting edge, only `gnt_a` rises. `gnt_b` is granted once A has been released, provided B is still requesting and the clock is low and not at its rising point.
- R8: `pause_cnt` increases by one for each reference edge at which a rise of `mclk` is held back by an active grant. It changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_sel | input | 2 | Half-period select (4, 5, 6 or 8 reference cycles) |
| req_a | input | 1 | Handshake request A (higher priority) |
| req_b | input | 1 | Handshake request B |
| mclk | output | 1 | Module clock |
| gnt_a | output | 1 | Grant to requester A |
| gnt_b | output | 1 | Grant to requester B |
| pause_cnt | output | PCW | Count of reference cycles spent held at the rising point |

## Verification
The assertions assume that a requester keeps its line high until its grant appears and then drops it after a finite time. Without that, the pause would never end and the grant checks would say nothing. The bench follows this pattern in every scenario. It changes its inputs only on falling reference edges, and it lowers each request after a bounded number of cycles. It changes `freq_sel` only between scenarios and waits two full clock periods before it measures anything.

// File: rtl/pausible_clkgen.sv
module pausible_clkgen #(
  parameter int HALF0 = 4,
  parameter int HALF1 = 5,
  parameter int HALF2 = 6,
  parameter int HALF3 = 8,
  parameter int PCW   = 16
) (
  input  logic           clk_ref,
  input  logic           rst_n,
  input  logic [1:0]     freq_sel,
  input  logic           req_a,
  input  logic           req_b,
  output logic           mclk,
  output logic           gnt_a,
  output logic           gnt_b,
  output logic [PCW-1:0] pause_cnt
);
  localparam int HM01 = (HALF0 > HALF1) ? HALF0 : HALF1;
  localparam int HM23 = (HALF2 > HALF3) ? HALF2 : HALF3;
  localparam int HMAX = (HM01 > HM23) ? HM01 : HM23;
  localparam int CW   = $clog2(HMAX + 1);

  logic [CW-1:0] half, phase;
  logic          gnt, sel_b;

  always_comb begin
    case (freq_sel)
      2'd0:    half = CW'(HALF0);
      2'd1:    half = CW'(HALF1);
      2'd2:    half = CW'(HALF2);
      default: half = CW'(HALF3);
    endcase
  end

  wire at_end    = phase >= (half - 1'b1);
  wire merged    = req_a | req_b;
  wire owner_req = sel_b ? req_b : req_a;

  assign gnt_a = gnt & ~sel_b;
  assign gnt_b = gnt & sel_b;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      mclk      <= 1'b0;
      phase     <= '0;
      pause_cnt <= '0;
    end else if (!mclk) begin
      if (at_end) begin
        if (gnt) pause_cnt <= pause_cnt + 1'b1;
        else begin
          mclk  <= 1'b1;
          phase <= '0;
        end
      end else phase <= phase + 1'b1;
    end else if (at_end) begin
      mclk  <= 1'b0;
      phase <= '0;
    end else phase <= phase + 1'b1;
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      gnt   <= 1'b0;
      sel_b <= 1'b0;
    end else if (gnt) begin
      if (!owner_req) gnt <= 1'b0;
    end else if (merged && !mclk && !at_end) begin
      gnt   <= 1'b1;
      sel_b <= !req_a;
    end
  end

  wire any_g = gnt_a | gnt_b;

  AST_GNT_CLK_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
    any_g |-> !mclk); // R6
  AST_NO_RISE_IN_GNT: assert property (@(posedge clk_ref) disable iff (!rst_n)
    any_g |=> !mclk); // R6
  AST_GNT_A_REQ: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(gnt_a) |-> $past(req_a)); // R3
  AST_GNT_B_PRIO: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(gnt_b) |-> ($past(req_b) && !$past(req_a))); // R7
  AST_NO_GNT_HIGH: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(any_g) |-> !$past(mclk)); // R4
  AST_PAUSE_STEP: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (pause_cnt != $past(pause_cnt)) |-> (!mclk && $past(any_g))); // R8
endmodule

// File: tb/pausible_clkgen_test.sv
module pausible_clkgen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  freq_sel = 2'd0;
  logic        req_a = 1'b0, req_b = 1'b0;
  logic        mclk, gnt_a, gnt_b;
  logic [15:0] pause_cnt;
  int total = 0, bad = 0, cyc = 0;

  pausible_clkgen uut (.clk_ref(clk), .rst_n(rst_n), .freq_sel(freq_sel),
    .req_a(req_a), .req_b(req_b), .mclk(mclk), .gnt_a(gnt_a), .gnt_b(gnt_b),
    .pause_cnt(pause_cnt));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_edge(input logic lvl);
    while (mclk == lvl) tick;
    while (mclk != lvl) tick;
  endtask

  function automatic int hexp(input int s);
    case (s)
      0: return 4;
      1: return 5;
      2: return 6;
      default: return 8;
    endcase
  endfunction

  initial begin
    int n, h, p0;
    repeat (3) tick;
    check("R1 mclk", mclk, 0);
    check("R1 gnt", {gnt_a, gnt_b}, 0);
    check("R1 pause", pause_cnt, 0);
    rst_n = 1'b1;

    for (int s = 0; s < 4; s++) begin
      freq_sel = 2'(s);
      h = hexp(s);
      wait_edge(1); wait_edge(1);

      // R2 free-running phase lengths
      n = 1; tick;
      while (mclk) begin n++; tick; end
      check($sformatf("R2 high sel=%0d", s), n, h);
      n = 1; tick;
      while (!mclk) begin n++; tick; end
      check($sformatf("R2 low sel=%0d", s), n, h);

      // R3 / R6 short grant in low phase
      wait_edge(0);
      req_a = 1'b1; tick;
      check("R3 gnt_a", gnt_a, 1);
      check("R3 gnt_b", gnt_b, 0);
      req_a = 1'b0; tick;
      check("R6 release", gnt_a, 0);
      n = 3; tick;
      while (!mclk) begin n++; tick; end
      check($sformatf("R6 short low sel=%0d", s), n, h);

      // R6 / R8 long grant stretches low phase
      wait_edge(0);
      p0 = pause_cnt;
      req_a = 1'b1; tick;
      repeat (10) tick;
      check("R6 held low", mclk, 0);
      check("R6 held gnt", gnt_a, 1);
      req_a = 1'b0;
      n = 12; tick;
      while (!mclk) begin n++; tick; end
      check($sformatf("R6 stretched low sel=%0d", s), n, 13);
      check($sformatf("R8 pause sel=%0d", s), pause_cnt - p0, 13 - h);

      // R4 request during high phase
      wait_edge(1);
      p0 = pause_cnt;
      req_b = 1'b1; n = 0;
      do begin tick; n++; end while (!gnt_b && n < 50);
      check($sformatf("R4 latency sel=%0d", s), n, h + 1);
      check("R4 mclk low", mclk, 0);
      req_b = 1'b0; tick;
      check("R8 no pause", pause_cnt - p0, 0);

      // R5 coincidence with rising edge
      wait_edge(0);
      repeat (h - 1) tick;
      req_a = 1'b1; tick;
      check($sformatf("R5 clock wins sel=%0d", s), mclk, 1);
      check("R5 no gnt", gnt_a, 0);
      n = 1;
      while (!gnt_a && n < 50) begin tick; n++; end
      check($sformatf("R5 latency sel=%0d", s), n, h + 2);
      req_a = 1'b0; tick;

      // R7 priority between inputs
      wait_edge(0);
      req_a = 1'b1; req_b = 1'b1; tick;
      check("R7 a wins", gnt_a, 1);
      check("R7 b waits", gnt_b, 0);
      req_a = 1'b0; tick;
      check("R7 released", {gnt_a, gnt_b}, 0);
      tick;
      check("R7 b granted", gnt_b, 1);
      check("R7 a idle", gnt_a, 0);
      req_b = 1'b0;
      wait_edge(1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule